// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps every in-flight instruction in a circular buffer in program order. Instructions may finish out of order, but they leave the buffer in order. When an instruction is dispatched, the block takes an entry at the tail. It records whether the instruction is a branch and which architectural register it targets. It returns the entry index, which the execution side uses as a tag. When a unit finishes, it broadcasts the tag together with the result. For a branch, the broadcast also carries a mispredict flag and the correct target. That entry then becomes ready.

Only the oldest entry can retire, and only once it is ready. A retiring ordinary instruction drives a one-cycle register write. A correctly predicted branch leaves quietly. A mispredicted branch at the head empties the whole buffer and pulses a redirect carrying the correct target.

Dispatch is a valid/ready stream. An item transfers on a clock edge where `iss_valid` and `iss_ready` are both high. `iss_ready` drops when every entry is occupied and in the cycle a flush happens. The source must then hold its item. Result broadcasts, register writes and the redirect are plain single-cycle pulses with no back-pressure.

Top module: `rob_ordered`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, and `wb_valid` and `redirect_valid` are 0.
- R2: Each accepted dispatch returns on `iss_tag` the tail index. Tags count up by one per accepted item and wrap from DEPTH-1 to 0.
- R3: With DEPTH entries occupied, `iss_ready` is 0 and a presented item is not taken. The next accepted item receives the tag that follows the last accepted one.
- R4: An entry does not retire before it is at the head and ready. Results for younger entries cause no register write while the head is still waiting.
- R5: A ready non-branch head drives `wb_valid` for one cycle with its destination and result, one cycle after its result broadcast is taken or after the older entry retires. Entries retire in dispatch order, at most one per cycle.
- R6: A ready branch head with mispredict flag 0 retires with no register write and no redirect.
- R7: A ready branch head with mispredict flag 1 pulses `redirect_valid` for exactly one cycle with its target. All entries are discarded, so younger results are never written. Afterwards the buffer is empty and the next tag is 0.
- R8: In the redirect cycle `iss_ready` is 0, so the flush wins over any dispatch.
- R9: A result broadcast naming an entry that is not occupied is ignored. An entry dispatched there later still waits for its own result.
- R10: A dispatch and a retirement can happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Dispatch item present |
| iss_ready | output | 1 | Buffer can take the item this cycle |
| iss_branch | input | 1 | 1 = branch, 0 = register-writing operation |
| iss_dst | input | REG_W | Destination register index |
| iss_tag | output | PTR_W | Entry index given to the item |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | PTR_W | Entry the result belongs to |
| res_value | input | DATA_W | Result value |
| res_mispredict | input | 1 | Branch was mispredicted |
| res_target | input | ADDR_W | Correct branch target |
| wb_valid | output | 1 | Register write this cycle |
| wb_dst | output | REG_W | Register written |
| wb_value | output | DATA_W | Value written |
| redirect_valid | output | 1 | Fetch restart pulse |
| redirect_target | output | ADDR_W | Restart address |

## Verification
The bench feeds several result orders:
- Results in reverse of dispatch order show whether retirement waits on the head.
- A completely full buffer with an extra item held on the dispatch port tests back-pressure.
- A correct and a mispredicted branch, each with results already broadcast for younger entries, show whether a flush drops exactly the younger work.
- A result aimed at an empty slot, and a dispatch overlapping a retirement, separate stale-tag handling from the ordinary paths.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    KIND_REG    = 1'b0,
    KIND_BRANCH = 1'b1
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full = (count == CAP);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc)  tail <= bump(tail);
      if (retire) head <= bump(head);
      case ({alloc, retire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  // R3
  no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc);

  // R5
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !flush) |=> head == bump($past(head)));
endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic              res_valid,
  input  logic [PTR_W-1:0]  res_idx,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_mis,
  input  logic [ADDR_W-1:0] res_tgt,
  input  logic              retire,
  input  logic [PTR_W-1:0]  head_idx,
  output logic              h_busy,
  output logic              h_ready,
  output rob_kind_e         h_kind,
  output logic [REG_W-1:0]  h_dst,
  output logic [DATA_W-1:0] h_value,
  output logic              h_mis,
  output logic [ADDR_W-1:0] h_tgt
);
  logic              busy_q  [DEPTH];
  logic              ready_q [DEPTH];
  rob_kind_e         kind_q  [DEPTH];
  logic [REG_W-1:0]  dst_q   [DEPTH];
  logic [DATA_W-1:0] val_q   [DEPTH];
  logic              mis_q   [DEPTH];
  logic [ADDR_W-1:0] tgt_q   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PTR_W-1:0] ME = PTR_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        busy_q[g]  <= 1'b0;
        ready_q[g] <= 1'b0;
        kind_q[g]  <= KIND_REG;
        dst_q[g]   <= '0;
        val_q[g]   <= '0;
        mis_q[g]   <= 1'b0;
        tgt_q[g]   <= '0;
      end else if (alloc && alloc_idx == ME) begin
        busy_q[g]  <= 1'b1;
        ready_q[g] <= 1'b0;
        kind_q[g]  <= alloc_kind;
        dst_q[g]   <= alloc_dst;
        mis_q[g]   <= 1'b0;
      end else if (retire && head_idx == ME) begin
        busy_q[g]  <= 1'b0;
        ready_q[g] <= 1'b0;
      end else if (res_valid && res_idx == ME && busy_q[g]) begin
        ready_q[g] <= 1'b1;
        val_q[g]   <= res_value;
        mis_q[g]   <= res_mis;
        tgt_q[g]   <= res_tgt;
      end
    end
  end

  assign h_busy  = busy_q[head_idx];
  assign h_ready = ready_q[head_idx];
  assign h_kind  = kind_q[head_idx];
  assign h_dst   = dst_q[head_idx];
  assign h_value = val_q[head_idx];
  assign h_mis   = mis_q[head_idx];
  assign h_tgt   = tgt_q[head_idx];

  // R3
  alloc_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy_q[alloc_idx]);

  // R4
  retire_ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (busy_q[head_idx] && ready_q[head_idx]));
endmodule

// File: rtl/rob_ordered.sv
module rob_ordered
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic              iss_branch,
  input  logic [REG_W-1:0]  iss_dst,
  output logic [PTR_W-1:0]  iss_tag,
  input  logic              res_valid,
  input  logic [PTR_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic              res_mispredict,
  input  logic [ADDR_W-1:0] res_target,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_value,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_target
);
  logic [PTR_W-1:0]  head, tail;
  logic              full, alloc, retire, flush, head_done;
  logic              h_busy, h_ready, h_mis;
  rob_kind_e         h_kind;
  logic [REG_W-1:0]  h_dst;
  logic [DATA_W-1:0] h_value;
  logic [ADDR_W-1:0] h_tgt;

  assign head_done = h_busy && h_ready;
  assign flush     = head_done && (h_kind == KIND_BRANCH) && h_mis;
  assign retire    = head_done && !flush;
  assign iss_ready = !full && !flush;
  assign alloc     = iss_valid && iss_ready;
  assign iss_tag   = tail;

  assign wb_valid        = retire && (h_kind == KIND_REG);
  assign wb_dst          = h_dst;
  assign wb_value        = h_value;
  assign redirect_valid  = flush;
  assign redirect_target = h_tgt;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire), .flush(flush),
    .head(head), .tail(tail), .full(full)
  );

  rob_slots #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc(alloc), .alloc_idx(tail),
    .alloc_kind(iss_branch ? KIND_BRANCH : KIND_REG), .alloc_dst(iss_dst),
    .res_valid(res_valid), .res_idx(res_tag), .res_value(res_value),
    .res_mis(res_mispredict), .res_tgt(res_target),
    .retire(retire), .head_idx(head),
    .h_busy(h_busy), .h_ready(h_ready), .h_kind(h_kind), .h_dst(h_dst),
    .h_value(h_value), .h_mis(h_mis), .h_tgt(h_tgt)
  );

  // R7
  redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  // R7
  redirect_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (iss_ready && iss_tag == '0 && !wb_valid));

  // R8
  flush_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !iss_ready);

  // R6
  wb_redirect_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && redirect_valid));
endmodule

// File: tb/test_rob_ordered.sv
module test_rob_ordered;
  localparam int DEPTH = 8, REG_W = 5, DATA_W = 32, ADDR_W = 32, PTR_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0, iss_branch = 1'b0;
  logic [REG_W-1:0] iss_dst = '0;
  logic iss_ready;
  logic [PTR_W-1:0] iss_tag;
  logic res_valid = 1'b0, res_mispredict = 1'b0;
  logic [PTR_W-1:0] res_tag = '0;
  logic [DATA_W-1:0] res_value = '0;
  logic [ADDR_W-1:0] res_target = '0;
  logic wb_valid, redirect_valid;
  logic [REG_W-1:0] wb_dst;
  logic [DATA_W-1:0] wb_value;
  logic [ADDR_W-1:0] redirect_target;

  always #4 clk = ~clk;

  rob_ordered #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rob_ordered (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_branch(iss_branch), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .res_mispredict(res_mispredict), .res_target(res_target),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_value(wb_value),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target)
  );

  int total = 0, bad = 0, wb_seen = 0, redir_seen = 0, exp_tail = 0;
  bit wb_at_issue;
  logic [ADDR_W-1:0] exp_redirect = '0;
  logic [REG_W+DATA_W-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_issue(input bit br, input logic [REG_W-1:0] dst,
                          input logic [DATA_W-1:0] val, input bit expect_wb);
    @(negedge clk);
    wb_at_issue = wb_valid;
    iss_valid = 1'b1; iss_branch = br; iss_dst = dst;
    #1;
    check(iss_ready == 1'b1, "R2 ready", longint'(iss_ready), 1);
    check(iss_tag == PTR_W'(exp_tail), "R2 tag", longint'(iss_tag), exp_tail);
    if (expect_wb) exp_q.push_back({dst, val});
    @(posedge clk); #1;
    iss_valid = 1'b0;
    exp_tail = (exp_tail + 1) % DEPTH;
  endtask

  task automatic do_result(input int tag, input logic [DATA_W-1:0] val,
                           input bit mis, input logic [ADDR_W-1:0] tgt);
    @(negedge clk);
    res_valid = 1'b1; res_tag = PTR_W'(tag); res_value = val;
    res_mispredict = mis; res_target = tgt;
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  // monitor: pop expected writes in order and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_valid) begin
        wb_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R7 unexpected write", longint'(wb_dst), 0);
        end else begin
          logic [REG_W+DATA_W-1:0] e;
          e = exp_q.pop_front();
          check({wb_dst, wb_value} == e, "R5 write order/data",
                longint'({wb_dst, wb_value}), longint'(e));
        end
      end
      if (redirect_valid) begin
        redir_seen++;
        check(redirect_target == exp_redirect, "R7 target",
              longint'(redirect_target), longint'(exp_redirect));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(iss_ready == 1'b1, "R1 ready", longint'(iss_ready), 1);
    check(iss_tag == '0, "R1 tag", longint'(iss_tag), 0);
    check(!wb_valid && !redirect_valid, "R1 idle", longint'({wb_valid, redirect_valid}), 0);

    // R4: results in reverse order, head held back
    do_issue(0, 5'd1, 32'h11, 1);
    do_issue(0, 5'd2, 32'h22, 1);
    do_issue(0, 5'd3, 32'h33, 1);
    do_result(2, 32'h33, 0, '0);
    do_result(1, 32'h22, 0, '0);
    repeat (3) @(negedge clk);
    check(wb_seen == 0, "R4 no early retire", wb_seen, 0);
    do_result(0, 32'h11, 0, '0);
    repeat (4) @(negedge clk);
    check(wb_seen == 3, "R5 three writes", wb_seen, 3);

    // R3: fill all entries, tags wrap (R2)
    for (int i = 0; i < DEPTH; i++) do_issue(0, REG_W'(8 + i), 32'h100 + i, 1);
    @(negedge clk);
    check(iss_ready == 1'b0, "R3 full not ready", longint'(iss_ready), 0);
    iss_valid = 1'b1; iss_dst = 5'd31; iss_branch = 1'b0;
    @(posedge clk); #1; iss_valid = 1'b0;
    for (int i = DEPTH - 1; i >= 1; i--) do_result((3 + i) % DEPTH, 32'h100 + i, 0, '0);
    repeat (2) @(negedge clk);
    check(wb_seen == 3, "R4 head blocks younger", wb_seen, 3);
    do_result(3, 32'h100, 0, '0);
    repeat (12) @(negedge clk);
    check(wb_seen == 3 + DEPTH, "R3 drained", wb_seen, 3 + DEPTH);

    // R3 ignored item consumed no tag; R10 issue alongside retire
    do_issue(0, 5'd4, 32'h44, 1);
    do_result(3, 32'h44, 0, '0);
    do_issue(0, 5'd5, 32'h55, 1);
    check(wb_at_issue == 1'b1, "R10 retire with issue", longint'(wb_at_issue), 1);
    do_result(4, 32'h55, 0, '0);
    repeat (3) @(negedge clk);

    // R6: correctly predicted branch
    base = redir_seen;
    do_issue(0, 5'd6, 32'h66, 1);
    do_issue(1, 5'd0, '0, 0);
    do_issue(0, 5'd7, 32'h77, 1);
    do_result(7, 32'h77, 0, '0);
    do_result(6, 32'h0, 0, 32'hdead);
    do_result(5, 32'h66, 0, '0);
    repeat (5) @(negedge clk);
    check(redir_seen == base, "R6 no redirect", redir_seen, base);
    check(exp_q.size() == 0, "R6 writes done", exp_q.size(), 0);

    // R7/R8: mispredicted branch
    do_issue(0, 5'd8, 32'h88, 1);
    do_issue(1, 5'd0, '0, 0);
    do_issue(0, 5'd9, 32'h99, 0);
    exp_redirect = 32'h1234;
    do_result(2, 32'h99, 0, '0);
    do_result(0, 32'h88, 0, '0);
    do_result(1, 32'h0, 1, 32'h1234);
    @(negedge clk);
    check(redirect_valid == 1'b1, "R7 redirect pulse", longint'(redirect_valid), 1);
    check(iss_ready == 1'b0, "R8 flush over issue", longint'(iss_ready), 0);
    iss_valid = 1'b1; iss_dst = 5'd30;
    @(posedge clk); #1; iss_valid = 1'b0;
    @(negedge clk);
    check(redirect_valid == 1'b0, "R7 one cycle", longint'(redirect_valid), 0);
    check(iss_ready == 1'b1 && iss_tag == '0, "R7 empty after flush",
          longint'({iss_ready, iss_tag}), 8);
    exp_tail = 0;
    repeat (3) @(negedge clk);
    check(redir_seen == base + 1, "R7 single redirect", redir_seen, base + 1);

    // R9: stray result on empty slot
    do_result(0, 32'h5a5a, 0, '0);
    base = wb_seen;
    do_issue(0, 5'd10, 32'hab, 1);
    repeat (3) @(negedge clk);
    check(wb_seen == base, "R9 stray ignored", wb_seen, base);
    do_result(0, 32'hab, 0, '0);
    repeat (3) @(negedge clk);
    check(wb_seen == base + 1, "R9 real result", wb_seen, base + 1);
    check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule